// File: doc/BRIEF.md
# Synchronizable Segment Blink Controller

This block produces the square blanking request that makes a multiplexed LED display blink. A slow timebase tick, derived from the scan oscillator outside the block, advances a phase counter. Each phase, dark or lit, lasts a fixed number of ticks. A rate-select input picks between a short phase and a long phase. While blinking is enabled, the block asserts its blank output for every dark phase, and the scanner then forces all segments off.

Blink settings come in as four static control bits: enable, rate select, start phase and sync enable. A one-cycle strobe marks the rising edge of the serial load line. When sync is enabled, that strobe restarts the blink sequence. It also raises a one-cycle clear pulse for the multiplex counter, so several chained display drivers that share the load line blink in step. Enabling blinking also restarts the sequence. In both cases the sequence restarts in the phase that the start-phase bit selects. A change of rate is held back until the current phase ends, so no phase is ever cut short.

Top module: `seg_blink_ctrl`

## Requirements
- R1: While the enable input is low, the blank output is low from the next clock onward, whatever the ticks, rate or strobe inputs do.
- R2: On the clock where enable rises, the sequence restarts with the counter at zero. If the start-phase bit is 1, the first phase is lit (blank low). If it is 0, the first phase is dark (blank high).
- R3: With the rate-select bit 0, every phase lasts exactly FAST_TICKS ticks. The phase flips on the edge that takes the last tick.
- R4: With the rate-select bit 1, every phase lasts exactly the slow length. The slow length is SLOW_TICKS, or twice FAST_TICKS when SLOW_DOUBLE is 1.
- R5: A change of rate-select in the middle of a phase leaves that phase at its original length. The new length starts with the next phase.
- R6: A load strobe while sync is 1 drives the multiplex clear output high for exactly the next clock. It also restarts the blink sequence in the start phase, with the counter at zero.
- R7: A load strobe while sync is 0 produces no clear pulse and does not disturb the blink phase or count.
- R8: A restart (enable rise or sync strobe) in the same cycle as a tick wins over the tick, and that tick is not counted.
- R9: After reset, both blank and clear outputs are low.
- R10: While blinking stays enabled, the blank output changes only on a clock that carries a tick or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase tick |
| blink_en_i | input | 1 | Blinking enable |
| rate_slow_i | input | 1 | 0 = short phase, 1 = long phase |
| start_lit_i | input | 1 | Phase after a restart: 1 = lit, 0 = dark |
| sync_en_i | input | 1 | Lets the load strobe restart the sequence and clear the multiplex counter |
| load_rise_i | input | 1 | One-cycle strobe on the load line rising edge |
| blank_o | output | 1 | Blank request to the scanner, high in the dark phase |
| mux_clr_o | output | 1 | One-cycle clear pulse for the multiplex counter |

## Verification
The bench counts ticks precisely across phase boundaries at both rates. This exposes an off-by-one phase length, which would show up as the flip arriving one tick early or late. It flips the rate in mid-phase; a design that applied the new rate at once would end the current phase early or late. It sends load strobes with sync both set and cleared, and sends a sync strobe in the same cycle as a tick. A design that ignored the sync gate would restart and shift the phase, and one that let the tick through would flip a tick early. Each restart is taken with both start-phase values, so an inverted start bit shows up at the first sample.

// File: rtl/blink_pkg.sv
package blink_pkg;

   // Display phase held by the blink controller.
   typedef enum logic {
      PH_DARK = 1'b0,
      PH_LIT  = 1'b1
   } blink_phase_e;

   // Width needed to count 0 .. n-1, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/blink_restart.sv
module blink_restart (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic blink_en_i,
   input  logic sync_en_i,
   input  logic load_rise_i,
   output logic restart_o,
   output logic en_q_o,
   output logic mux_clr_o
);

   logic sync_hit;

   assign sync_hit  = sync_en_i & load_rise_i;
   assign restart_o = (blink_en_i & ~en_q_o) | sync_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q_o    <= 1'b0;
         mux_clr_o <= 1'b0;
      end else begin
         en_q_o    <= blink_en_i;
         mux_clr_o <= sync_hit;
      end
   end

   // R6: a gated strobe yields a clear pulse on the next clock
   assert_clr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_en_i && load_rise_i) |=> mux_clr_o);

   // R7: no gated strobe, no clear pulse
   assert_clr_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sync_en_i && load_rise_i) |=> !mux_clr_o);

endmodule

// File: rtl/blink_phase_timer.sv
module blink_phase_timer #(
   parameter int unsigned FAST_TICKS = 800,
   parameter int unsigned SLOW_TICKS = 1600,
   parameter int unsigned CNT_W      = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic run_i,
   input  logic tick_i,
   input  logic rate_slow_i,
   output logic phase_end_o
);

   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             rate_q;
   logic [CNT_W-1:0] last;

   generate
      if (FAST_TICKS < 1) begin : g_bad_fast
         $error("FAST_TICKS must be at least 1");
      end
      if (SLOW_TICKS < 1) begin : g_bad_slow
         $error("SLOW_TICKS must be at least 1");
      end
      if (SLOW_TICKS > (1 << CNT_W) || FAST_TICKS > (1 << CNT_W)) begin : g_bad_width
         $error("CNT_W too narrow for the phase length");
      end
   endgenerate

   assign last        = rate_q ? SLOW_LAST : FAST_LAST;
   assign phase_end_o = run_i & tick_i & ~restart_i & (cnt_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         rate_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q  <= '0;
         rate_q <= rate_slow_i;
      end else if (!run_i) begin
         cnt_q  <= '0;
      end else if (tick_i) begin
         if (phase_end_o) begin
            cnt_q  <= '0;
            rate_q <= rate_slow_i;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   // R3/R4: the count never passes the active phase length
   assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= last);

   // R5: the active rate is frozen inside a phase
   assert_rate_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!restart_i && !phase_end_o) |=> $stable(rate_q));

   // R8: a restart always leaves the counter at zero
   assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/seg_blink_ctrl.sv
module seg_blink_ctrl
   import blink_pkg::*;
#(
   parameter int unsigned FAST_TICKS  = 800,
   parameter bit          SLOW_DOUBLE = 1'b1,
   parameter int unsigned SLOW_TICKS  = 1600
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic blink_en_i,
   input  logic rate_slow_i,
   input  logic start_lit_i,
   input  logic sync_en_i,
   input  logic load_rise_i,
   output logic blank_o,
   output logic mux_clr_o
);

   localparam int unsigned SLOW_EFF = SLOW_DOUBLE ? (2 * FAST_TICKS) : SLOW_TICKS;
   localparam int unsigned LONGEST  = (SLOW_EFF > FAST_TICKS) ? SLOW_EFF : FAST_TICKS;
   localparam int unsigned CNT_W    = cnt_width(LONGEST);

   logic         restart;
   logic         en_q;
   logic         phase_end;
   blink_phase_e phase_q;

   blink_restart u_restart (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .blink_en_i  (blink_en_i),
      .sync_en_i   (sync_en_i),
      .load_rise_i (load_rise_i),
      .restart_o   (restart),
      .en_q_o      (en_q),
      .mux_clr_o   (mux_clr_o)
   );

   blink_phase_timer #(
      .FAST_TICKS (FAST_TICKS),
      .SLOW_TICKS (SLOW_EFF),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .restart_i   (restart),
      .run_i       (blink_en_i),
      .tick_i      (tick_i),
      .rate_slow_i (rate_slow_i),
      .phase_end_o (phase_end)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_DARK;
      end else if (restart) begin
         phase_q <= start_lit_i ? PH_LIT : PH_DARK;
      end else if (phase_end) begin
         phase_q <= (phase_q == PH_LIT) ? PH_DARK : PH_LIT;
      end
   end

   assign blank_o = en_q & (phase_q == PH_DARK);

   // R1: blinking disabled keeps the display unblanked
   assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blink_en_i |=> !blank_o);

   // R2/R6: after a restart with blinking on, the start bit sets the phase
   assert_start_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (restart && blink_en_i) |=> (blank_o == !$past(start_lit_i)));

   // R10: without tick or restart the blank request holds
   assert_blank_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blink_en_i && en_q && !restart && !tick_i) |=> $stable(blank_o));

endmodule

// File: tb/sim_seg_blink_ctrl.sv
module sim_seg_blink_ctrl;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       en;
      logic       rate;
      logic       start;
      logic       sync;
      logic       load;
      logic [3:0] ticks;
      logic       exp_blank;
      logic       exp_clr;
   } vec_t;

   // Phase lengths used here: fast 3 ticks, slow 5 ticks.
   localparam vec_t VECS [15] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0}, // R2 start dark
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0}, // R3 flip on 3rd tick
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0}, // R3 full fast phase
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0}, // R5 rate change mid-phase
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0}, // R5 old length kept
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0}, // R4 slow phase running
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 1'b0}, // R4 flip on 5th tick
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1}, // R6 sync restart lit
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0}, // R6 counter at zero
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0}, // R6 flip after 5
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b1, 1'b0}, // R7 ungated load ignored
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R1 disable
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1}, // R6 clear while disabled
      '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0}, // R2 start lit
      '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 1'b0}  // R3 lit phase length
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic en = 1'b0;
   logic rate = 1'b0;
   logic start = 1'b0;
   logic sync = 1'b0;
   logic load = 1'b0;
   logic blank;
   logic clr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   seg_blink_ctrl #(
      .FAST_TICKS  (3),
      .SLOW_DOUBLE (1'b0),
      .SLOW_TICKS  (5)
   ) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .blink_en_i  (en),
      .rate_slow_i (rate),
      .start_lit_i (start),
      .sync_en_i   (sync),
      .load_rise_i (load),
      .blank_o     (blank),
      .mux_clr_o   (clr)
   );

   task automatic check(input logic got, input logic exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(blank, 1'b0, "R9 blank in reset");
      check(clr, 1'b0, "R9 clear in reset");
      rst_n = 1'b1;
      step();
      check(blank, 1'b0, "R9 blank after reset");
      check(clr, 1'b0, "R9 clear after reset");

      for (int i = 0; i < 15; i++) begin
         en    = VECS[i].en;
         rate  = VECS[i].rate;
         start = VECS[i].start;
         sync  = VECS[i].sync;
         load  = VECS[i].load;
         tick  = 1'b0;
         step();
         load  = 1'b0;
         check(clr, VECS[i].exp_clr, $sformatf("R6/R7 clear vec %0d", i));
         for (int t = 0; t < int'(VECS[i].ticks); t++) begin
            tick = 1'b1;
            step();
         end
         tick = 1'b0;
         check(blank, VECS[i].exp_blank, $sformatf("R1-R7 blank vec %0d", i));
      end

      // R10: idle clocks without ticks leave blank unchanged (dark phase now)
      repeat (4) step();
      check(blank, 1'b1, "R10 hold without tick");

      // R8: sync restart together with a tick, start dark
      start = 1'b0;
      sync  = 1'b1;
      load  = 1'b1;
      tick  = 1'b1;
      step();
      load  = 1'b0;
      check(blank, 1'b1, "R8 restart to dark");
      repeat (2) step();
      tick = 1'b0;
      check(blank, 1'b1, "R8 tick dropped, still dark");
      tick = 1'b1;
      step();
      tick = 1'b0;
      check(blank, 1'b0, "R8 flip on third counted tick");

      // R1: disabled, ticks have no effect on blank
      en = 1'b0;
      tick = 1'b1;
      for (int k = 0; k < 8; k++) begin
         step();
         check(blank, 1'b0, "R1 disabled stays unblanked");
      end
      tick = 1'b0;

      // R7: ungated strobe while disabled gives no clear
      sync = 1'b0;
      load = 1'b1;
      step();
      load = 1'b0;
      check(clr, 1'b0, "R7 no clear without sync");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule